// File: doc/BRIEF.md
# LPC I/O Cycle Target

This block is the peripheral end of a Low Pin Count bus. It watches the active-low frame strobe and the shared 4-bit nibble bus, and it recognises host-initiated I/O read and I/O write cycles. It answers a cycle only when the cycle's 16-bit address falls inside a window set by a base and a mask parameter. For a cycle it claims, it lets the host turnaround pass, then returns a SYNC nibble. On a read, it also returns one data byte as two nibbles. It then hands the bus back with its own two-clock turnaround.

On the chip side the block offers a plain register-access port. This port has an address, write data, one-clock write and read strobes, read data and an error flag. The port has no back-pressure. A strobe is never held or retried. The attached logic must present read data and the error flag in the clock that follows the strobe, and the block samples them at the end of that clock. An error flag turns the SYNC into an error SYNC.

The bus side uses a split pad interface with three signals: `lad_in` carries the resolved bus value, `lad_out` carries the nibble the block drives, and `lad_oe` enables that drive. The pull-ups sit outside the block. The DMA request output is always held inactive.

Top module: `lpc_io_target`

## Requirements
- R1: A cycle begins only when `frame_n` is low and `lad_in` equals 4'b0000 in the same clock. Any other nibble seen under a low `frame_n` leaves the block idle, and it neither drives the bus nor pulses a strobe.
- R2: The nibble after START selects the cycle. Bits [3:2] must be 2'b00 (I/O) and bit 1 gives the direction: 0 for read, 1 for write. Any other value of bits [3:2] makes the block ignore the cycle.
- R3: The address arrives as four nibbles, most significant first. A cycle is claimed when ((addr ^ BASE) & MASK) == 0. An unclaimed cycle gets no bus drive and no strobe.
- R4: On a write, the host sends two data nibbles, low nibble first, before its turnaround. `reg_wr` then pulses for exactly the first host-turnaround clock, carrying `reg_addr` and `reg_wdata`. `reg_wr` and `reg_rd` are never high together.
- R5: On a read, `reg_rd` pulses for exactly the first host-turnaround clock. `reg_rdata` and `reg_err` are taken at the end of the following clock, and after SYNC the byte goes out low nibble first, then high nibble.
- R6: During both host-turnaround clocks, `lad_oe` stays low.
- R7: The SYNC nibble is 4'b0000 when `reg_err` was low and 4'b1010 when it was high.
- R8: After an error SYNC on a read, the block still sends the two data nibbles in the next two clocks.
- R9: After its last driven nibble (SYNC on a write, high data nibble on a read), the block drives 4'b1111 for one clock, releases the bus in the next clock, and then returns to idle.
- R10: A low `frame_n` in the middle of a cycle aborts that cycle. `lad_oe` is low in the next clock, and the nibble seen in the abort clock is treated as a possible START.
- R11: While `rst_n` is low, and immediately after it falls, `lad_oe` is low and `frame_n` has no effect.
- R12: `ldrq_n` is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low cycle frame strobe |
| lad_in | input | 4 | Resolved value of the shared nibble bus |
| lad_out | output | 4 | Nibble driven onto the bus |
| lad_oe | output | 1 | Drive enable for lad_out |
| ldrq_n | output | 1 | Active-low DMA request, held inactive |
| reg_addr | output | 16 | Register address of the claimed cycle |
| reg_wdata | output | 8 | Write data, valid with reg_wr |
| reg_wr | output | 1 | One-clock write strobe |
| reg_rd | output | 1 | One-clock read strobe |
| reg_rdata | input | 8 | Read data, valid the clock after reg_rd |
| reg_err | input | 1 | Error flag, valid the clock after a strobe |

## Verification
Two functions can occur in the same clock: aborting a running cycle and recognising a new START. This happens because the nibble that cuts a cycle short is also the candidate START of the next one. The bench provokes it by cutting off a read after two address nibbles with a fresh START, then running a complete write straight after. The check is that the bus stays released and that the write lands with the right address and data. A second overlap is reset arriving while the block is driving SYNC. The bench judges this by seeing the drive enable drop within the same clock.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TYPE,
    ST_ADDR,
    ST_WDAT,
    ST_HTA1,
    ST_HTA2,
    ST_SYNC,
    ST_RDAT,
    ST_PTA1,
    ST_PTA2
  } lpc_st_e;

  localparam logic [NIB_W-1:0] NIB_START_IO = 4'b0000;
  localparam logic [NIB_W-1:0] NIB_SYNC_OK  = 4'b0000;
  localparam logic [NIB_W-1:0] NIB_SYNC_ERR = 4'b1010;
  localparam logic [NIB_W-1:0] NIB_HIGH     = 4'b1111;
endpackage

// File: rtl/lpc_win_decode.sv
module lpc_win_decode #(
  parameter int              ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter logic [ADDR_W-1:0] MASK = '1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  // Only bits set in MASK take part in the comparison.
  assign hit = (((addr ^ BASE) & MASK) == '0);
endmodule

// File: rtl/lpc_cycle_fsm.sv
module lpc_cycle_fsm
  import lpc_tgt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [NIB_W-1:0]  lad_in,
  input  logic              win_hit,
  output logic [ADDR_W-1:0] addr_next,
  output lpc_st_e           st,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              reg_err,
  output logic              err_flag,
  output logic [NIB_W-1:0]  rd_nib
);
  localparam int ADDR_NIBS = ADDR_W / NIB_W;
  localparam int DATA_NIBS = DATA_W / NIB_W;
  localparam int MAX_NIBS  = (ADDR_NIBS > DATA_NIBS) ? ADDR_NIBS : DATA_NIBS;
  localparam int CW        = $clog2(MAX_NIBS + 1);
  localparam logic [CW-1:0] ADDR_LAST = CW'(ADDR_NIBS - 1);
  localparam logic [CW-1:0] DATA_LAST = CW'(DATA_NIBS - 1);

  lpc_st_e           st_q;
  logic [CW-1:0]     cnt_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q;
  logic [DATA_W-1:0] rdat_q;
  logic              err_q;

  assign addr_next = {addr_q[ADDR_W-NIB_W-1:0], lad_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
      err_q  <= 1'b0;
    end else if (!frame_n) begin
      // A low frame strobe restarts START detection from any state.
      st_q  <= (lad_in == NIB_START_IO) ? ST_TYPE : ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: st_q <= ST_IDLE;
        ST_TYPE: begin
          if (lad_in[3:2] == 2'b00) begin
            wr_q  <= lad_in[1];
            st_q  <= ST_ADDR;
            cnt_q <= '0;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        ST_ADDR: begin
          addr_q <= addr_next;
          if (cnt_q == ADDR_LAST) begin
            cnt_q <= '0;
            if (!win_hit)  st_q <= ST_IDLE;
            else if (wr_q) st_q <= ST_WDAT;
            else           st_q <= ST_HTA1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WDAT: begin
          wdat_q <= {lad_in, wdat_q[DATA_W-1:NIB_W]};
          if (cnt_q == DATA_LAST) begin
            cnt_q <= '0;
            st_q  <= ST_HTA1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HTA1: st_q <= ST_HTA2;
        ST_HTA2: begin
          err_q <= reg_err;
          if (!wr_q) rdat_q <= reg_rdata;
          st_q <= ST_SYNC;
        end
        ST_SYNC: begin
          cnt_q <= '0;
          st_q  <= wr_q ? ST_PTA1 : ST_RDAT;
        end
        ST_RDAT: begin
          rdat_q <= rdat_q >> NIB_W;
          if (cnt_q == DATA_LAST) begin
            cnt_q <= '0;
            st_q  <= ST_PTA1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PTA1: st_q <= ST_PTA2;
        ST_PTA2: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st        = st_q;
  assign reg_addr  = addr_q;
  assign reg_wdata = wdat_q;
  assign reg_wr    = (st_q == ST_HTA1) &&  wr_q;
  assign reg_rd    = (st_q == ST_HTA1) && !wr_q;
  assign err_flag  = err_q;
  assign rd_nib    = rdat_q[NIB_W-1:0];
endmodule

// File: rtl/lpc_pad_drive.sv
module lpc_pad_drive
  import lpc_tgt_pkg::*;
(
  input  lpc_st_e          st,
  input  logic             err_flag,
  input  logic [NIB_W-1:0] rd_nib,
  output logic [NIB_W-1:0] lad_out,
  output logic             lad_oe,
  output logic             ldrq_n
);
  always_comb begin
    lad_oe  = 1'b0;
    lad_out = '0;
    unique case (st)
      ST_SYNC: begin
        lad_oe  = 1'b1;
        lad_out = err_flag ? NIB_SYNC_ERR : NIB_SYNC_OK;
      end
      ST_RDAT: begin
        lad_oe  = 1'b1;
        lad_out = rd_nib;
      end
      ST_PTA1: begin
        lad_oe  = 1'b1;
        lad_out = NIB_HIGH;
      end
      default: begin
        lad_oe  = 1'b0;
        lad_out = '0;
      end
    endcase
  end

  // No DMA channel is served, so the request stays inactive.
  assign ldrq_n = 1'b1;
endmodule

// File: rtl/lpc_io_target.sv
module lpc_io_target
  import lpc_tgt_pkg::*;
#(
  parameter int                ADDR_W = 16,
  parameter int                DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE   = 16'h0300,
  parameter logic [ADDR_W-1:0] MASK   = 16'hFFF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [3:0]        lad_in,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  output logic              ldrq_n,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              reg_err
);
  logic [ADDR_W-1:0] addr_next;
  logic              win_hit;
  lpc_st_e           fsm_st;
  logic              err_flag;
  logic [NIB_W-1:0]  rd_nib;

  lpc_win_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .MASK(MASK)) u_dec (
    .addr (addr_next),
    .hit  (win_hit)
  );

  lpc_cycle_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .lad_in    (lad_in),
    .win_hit   (win_hit),
    .addr_next (addr_next),
    .st        (fsm_st),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .reg_err   (reg_err),
    .err_flag  (err_flag),
    .rd_nib    (rd_nib)
  );

  lpc_pad_drive u_pad (
    .st       (fsm_st),
    .err_flag (err_flag),
    .rd_nib   (rd_nib),
    .lad_out  (lad_out),
    .lad_oe   (lad_oe),
    .ldrq_n   (ldrq_n)
  );
endmodule

// File: rtl/lpc_io_target_chk.sv
module lpc_io_target_chk
  import lpc_tgt_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic [3:0] lad_out,
  input logic       lad_oe,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic       reg_err,
  input lpc_st_e    st
);
  p_abort_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> !lad_oe);

  p_host_tar_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HTA1 || st == ST_HTA2) |-> !lad_oe);

  p_sync_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SYNC) |-> (lad_oe && (lad_out == 4'b0000 || lad_out == 4'b1010)));

  p_err_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HTA2 && reg_err && frame_n) |=> (lad_oe && lad_out == 4'b1010));

  p_tar_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PTA1) |-> (lad_oe && lad_out == 4'b1111));

  p_tar_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PTA1) |=> !lad_oe);

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  p_rd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
endmodule

bind lpc_io_target lpc_io_target_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .frame_n (frame_n),
  .lad_out (lad_out),
  .lad_oe  (lad_oe),
  .reg_wr  (reg_wr),
  .reg_rd  (reg_rd),
  .reg_err (reg_err),
  .st      (fsm_st)
);

// File: tb/tb_lpc_io_target.sv
`timescale 1ns/1ps
module tb_lpc_io_target;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n   = 1'b0;
  logic       frame_n = 1'b1;
  logic       host_oe = 1'b0;
  logic [3:0] host_nib = 4'h0;
  logic [3:0] lad_bus;
  logic [3:0] lad_out;
  logic       lad_oe, ldrq_n;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wdata;
  logic        reg_wr, reg_rd;
  logic [7:0]  dev_rdata = 8'h00;
  logic        dev_err = 1'b0;

  // Resolved bus with external pull-ups.
  assign lad_bus = lad_oe ? lad_out : (host_oe ? host_nib : 4'hF);

  lpc_io_target dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_bus),
    .lad_out(lad_out), .lad_oe(lad_oe), .ldrq_n(ldrq_n),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_rdata(dev_rdata), .reg_err(dev_err)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int strobes = 0;

  typedef struct packed { logic oe; logic [3:0] val; } bus_exp_t;
  typedef struct packed { logic wr; logic [15:0] a; logic [7:0] d; } reg_exp_t;
  bus_exp_t bus_q[$];
  string    tag_q[$];
  reg_exp_t reg_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // One host clock: drive at the falling edge and queue the expected bus state.
  task automatic hclk(input bit fr, input bit hoe, input logic [3:0] nib,
                      input bit eoe, input logic [3:0] ev, input string tag);
    @(negedge clk);
    frame_n  = fr;
    host_oe  = hoe;
    host_nib = nib;
    bus_q.push_back('{oe: eoe, val: ev});
    tag_q.push_back(tag);
  endtask

  // Monitor: compares bus behaviour with the queued expectation.
  always @(negedge clk) begin
    #1;
    if (bus_q.size() > 0) begin
      bus_exp_t e;
      string t;
      e = bus_q.pop_front();
      t = tag_q.pop_front();
      chk(lad_oe == e.oe, {t, " drive enable"}, 32'(lad_oe), 32'(e.oe));
      if (e.oe) chk(lad_out == e.val, {t, " nibble"}, 32'(lad_out), 32'(e.val));
      chk(!(lad_oe && host_oe), "R6 bus contention", 32'(lad_oe), 32'd0);
      chk(ldrq_n == 1'b1, "R12 ldrq_n", 32'(ldrq_n), 32'd1);
    end
    if (rst_n && (reg_wr || reg_rd)) begin
      strobes++;
      if (reg_q.size() == 0) begin
        chk(1'b0, "R3 unexpected strobe", 32'(reg_addr), 32'd0);
      end else begin
        reg_exp_t r;
        r = reg_q.pop_front();
        chk(reg_wr == r.wr, "R4/R5 strobe kind", 32'(reg_wr), 32'(r.wr));
        chk(reg_addr == r.a, "R3 reg_addr", 32'(reg_addr), 32'(r.a));
        if (r.wr) chk(reg_wdata == r.d, "R4 reg_wdata", 32'(reg_wdata), 32'(r.d));
      end
    end
  end

  task automatic io_cycle(input bit wr, input logic [15:0] a, input logic [7:0] d,
                          input bit err, input bit hit, input string tag);
    dev_err   = err;
    dev_rdata = d;
    hclk(1'b0, 1'b1, 4'h0, 1'b0, 4'h0, {tag, " R1 start"});
    hclk(1'b1, 1'b1, {2'b00, wr, 1'b0}, 1'b0, 4'h0, {tag, " R2 type"});
    for (int i = 0; i < 4; i++)
      hclk(1'b1, 1'b1, a[15-4*i -: 4], 1'b0, 4'h0, {tag, " R3 addr"});
    if (wr) begin
      hclk(1'b1, 1'b1, d[3:0], 1'b0, 4'h0, {tag, " R4 wdata lo"});
      hclk(1'b1, 1'b1, d[7:4], 1'b0, 4'h0, {tag, " R4 wdata hi"});
    end
    if (hit) reg_q.push_back('{wr: wr, a: a, d: d});
    hclk(1'b1, 1'b1, 4'hF, 1'b0, 4'h0, {tag, " R6 host tar1"});
    hclk(1'b1, 1'b0, 4'h0, 1'b0, 4'h0, {tag, " R6 host tar2"});
    hclk(1'b1, 1'b0, 4'h0, hit, err ? 4'hA : 4'h0, {tag, " R7 sync"});
    if (!wr) begin
      hclk(1'b1, 1'b0, 4'h0, hit, d[3:0], {tag, " R5/R8 data lo"});
      hclk(1'b1, 1'b0, 4'h0, hit, d[7:4], {tag, " R5/R8 data hi"});
    end
    hclk(1'b1, 1'b0, 4'h0, hit, 4'hF, {tag, " R9 tar high"});
    hclk(1'b1, 1'b0, 4'h0, 1'b0, 4'h0, {tag, " R9 tar float"});
    hclk(1'b1, 1'b0, 4'h0, 1'b0, 4'h0, {tag, " R9 idle"});
    dev_err = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int s0;
    // R11: reset holds the bus released and ignores frame.
    host_oe = 1'b1; host_nib = 4'h0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      frame_n = (i % 2 == 0) ? 1'b0 : 1'b1;
      #1;
      chk(lad_oe == 1'b0, "R11 reset lad_oe", 32'(lad_oe), 32'd0);
      chk(ldrq_n == 1'b1, "R11 reset ldrq_n", 32'(ldrq_n), 32'd1);
    end
    @(negedge clk); frame_n = 1'b1; host_oe = 1'b0; rst_n = 1'b1;
    hclk(1'b1, 1'b0, 4'h0, 1'b0, 4'h0, "R11 after reset");

    io_cycle(1'b1, 16'h0305, 8'hA5, 1'b0, 1'b1, "R4 write hit");
    io_cycle(1'b0, 16'h030C, 8'h3C, 1'b0, 1'b1, "R5 read hit");
    io_cycle(1'b0, 16'h0301, 8'h5A, 1'b1, 1'b1, "R8 read err");
    io_cycle(1'b1, 16'h030F, 8'h81, 1'b1, 1'b1, "R7 write err");

    s0 = strobes;
    io_cycle(1'b0, 16'h0405, 8'h11, 1'b0, 1'b0, "R3 read miss");
    io_cycle(1'b1, 16'h1300, 8'h22, 1'b0, 1'b0, "R3 write miss");
    chk(strobes == s0, "R3 no strobe on miss", 32'(strobes), 32'(s0));

    // R1: non-zero START followed by a plausible read; no response.
    s0 = strobes;
    hclk(1'b0, 1'b1, 4'h5, 1'b0, 4'h0, "R1 bad start");
    hclk(1'b1, 1'b1, 4'h0, 1'b0, 4'h0, "R1 type");
    for (int i = 0; i < 4; i++) hclk(1'b1, 1'b1, (i == 1) ? 4'h3 : 4'h0, 1'b0, 4'h0, "R1 addr");
    hclk(1'b1, 1'b1, 4'hF, 1'b0, 4'h0, "R1 tar");
    for (int i = 0; i < 5; i++) hclk(1'b1, 1'b0, 4'h0, 1'b0, 4'h0, "R1 silent");
    // R2: memory read type (bits [3:2] = 01) is ignored.
    hclk(1'b0, 1'b1, 4'h0, 1'b0, 4'h0, "R2 start");
    hclk(1'b1, 1'b1, 4'b0100, 1'b0, 4'h0, "R2 mem type");
    for (int i = 0; i < 4; i++) hclk(1'b1, 1'b1, (i == 1) ? 4'h3 : 4'h0, 1'b0, 4'h0, "R2 addr");
    hclk(1'b1, 1'b1, 4'hF, 1'b0, 4'h0, "R2 tar");
    for (int i = 0; i < 5; i++) hclk(1'b1, 1'b0, 4'h0, 1'b0, 4'h0, "R2 silent");
    chk(strobes == s0, "R1 R2 no strobe", 32'(strobes), 32'(s0));

    // R10: abort a read after two address nibbles with a fresh START.
    hclk(1'b0, 1'b1, 4'h0, 1'b0, 4'h0, "R10 start");
    hclk(1'b1, 1'b1, 4'h0, 1'b0, 4'h0, "R10 type");
    hclk(1'b1, 1'b1, 4'h0, 1'b0, 4'h0, "R10 addr");
    hclk(1'b1, 1'b1, 4'h3, 1'b0, 4'h0, "R10 addr");
    io_cycle(1'b1, 16'h0307, 8'hC3, 1'b0, 1'b1, "R10 write after abort");

    // R11: reset while the block drives SYNC.
    dev_rdata = 8'h77;
    hclk(1'b0, 1'b1, 4'h0, 1'b0, 4'h0, "R11 start");
    hclk(1'b1, 1'b1, 4'h0, 1'b0, 4'h0, "R11 type");
    hclk(1'b1, 1'b1, 4'h0, 1'b0, 4'h0, "R11 addr");
    hclk(1'b1, 1'b1, 4'h3, 1'b0, 4'h0, "R11 addr");
    hclk(1'b1, 1'b1, 4'h0, 1'b0, 4'h0, "R11 addr");
    hclk(1'b1, 1'b1, 4'h2, 1'b0, 4'h0, "R11 addr");
    reg_q.push_back('{wr: 1'b0, a: 16'h0302, d: 8'h00});
    hclk(1'b1, 1'b1, 4'hF, 1'b0, 4'h0, "R11 tar1");
    hclk(1'b1, 1'b0, 4'h0, 1'b0, 4'h0, "R11 tar2");
    hclk(1'b1, 1'b0, 4'h0, 1'b1, 4'h0, "R11 sync before reset");
    #2 rst_n = 1'b0;
    #0.5;
    chk(lad_oe == 1'b0, "R11 mid-cycle reset lad_oe", 32'(lad_oe), 32'd0);
    chk(ldrq_n == 1'b1, "R11 mid-cycle reset ldrq_n", 32'(ldrq_n), 32'd1);
    @(negedge clk); frame_n = 1'b0; host_oe = 1'b1; host_nib = 4'h0;
    #1 chk(lad_oe == 1'b0, "R11 frame ignored in reset", 32'(lad_oe), 32'd0);
    @(negedge clk); frame_n = 1'b1; host_oe = 1'b0; rst_n = 1'b1;
    hclk(1'b1, 1'b0, 4'h0, 1'b0, 4'h0, "R11 released");

    io_cycle(1'b0, 16'h0300, 8'hF0, 1'b0, 1'b1, "R5 read after reset");

    repeat (3) @(negedge clk);
    chk(reg_q.size() == 0, "R4/R5 all strobes seen", 32'(reg_q.size()), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule